// File: doc/BRIEF.md
# Register Stack Frame Renamer

This block keeps the current frame marker of a windowed general register stack and turns virtual register numbers into physical register indices. The low registers are static and pass straight through. The upper registers come from a circular file of stacked physical registers, and the block reaches them through a frame base pointer. Call, allocate and return commands change the frame. A call turns the caller's outputs into the callee's inputs. An allocate resizes the current frame. A return restores the frame saved at the call.

The block also counts how many ancestor registers still sit in the physical file. When a command needs more registers than the file holds, the block stalls it in state `ST_SPILL`. It reports the shortfall to a spill engine and waits for one acknowledge per register moved out. When a return finds that some of the caller's locals are no longer in the file, the block stalls in state `ST_FILL` and waits for one acknowledge per register brought back. From `ST_IDLE` an accepted command either commits at once (transition *accept*), or moves to `ST_SPILL` (*stall-for-spill*) or `ST_FILL` (*stall-for-fill*). The acknowledge that brings the remaining count down from one causes the *commit* transition back to `ST_IDLE`, and the new frame takes effect at that edge.

Top module: `reg_stack_renamer`

## Requirements
- R1: A virtual number below 32 maps to the same index, with `map_static` and `map_legal` both high.
- R2: A virtual number v of 32 or more is legal only when v-32 is less than the current frame size. When legal it maps to (base + v - 32) mod 96, with `map_static` low.
- R3: An accepted allocate (`cmd_op` 2'b10) sets frame size to inputs+locals+outputs and local size to inputs+locals. The base does not change. The new frame is visible in the cycle after the accepting edge.
- R4: An accepted call (`cmd_op` 2'b01) saves the current frame as the previous frame. It sets frame size to the old size minus the old local size and local size to 0, and advances the base by the old local size, mod 96.
- R5: An accepted return (`cmd_op` 2'b11) restores frame and local sizes from the saved previous frame and moves the base back by the restored local size, mod 96.
- R6: After reset the frame and local sizes are 0, `cmd_ready` is high, and neither stall request is raised.
- R7: When a command would leave more than 96 registers resident, `ovf_req` rises with `ovf_count` equal to the shortfall and `cmd_ready` drops. The visible frame is held. Each `spill_ack` lowers the count by one, and the acknowledge at count 1 commits the command.
- R8: When a return needs more caller locals than are resident, `unf_req` rises with `unf_count` equal to the missing number. The frame is held until that many `fill_ack` pulses arrive, and the last one commits the return.
- R9: An allocate whose total exceeds 96 is dropped and the frame is unchanged. A total of exactly 96 is accepted.
- R10: `spill_ack` and `fill_ack` outside a stall have no effect on the resident count, which later shortfall values reveal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 call, 10 allocate, 11 return, 00 none |
| alloc_ins | input | 7 | Input count for allocate |
| alloc_locs | input | 7 | Local count for allocate |
| alloc_outs | input | 7 | Output count for allocate |
| cmd_ready | output | 1 | High when a command can be accepted |
| spill_ack | input | 1 | One register spilled |
| fill_ack | input | 1 | One register filled |
| ovf_req | output | 1 | Spill needed, command stalled |
| ovf_count | output | 7 | Registers still to spill |
| unf_req | output | 1 | Fill needed, return stalled |
| unf_count | output | 7 | Registers still to fill |
| vreg_num | input | 7 | Virtual register to translate |
| map_idx | output | 7 | Static or physical stacked index |
| map_static | output | 1 | Register is static |
| map_legal | output | 1 | Register lies in the current frame |
| frame_sof | output | 7 | Current frame size |
| frame_sol | output | 7 | Current local size |

## Verification
The fill path is the hardest state to reach from the ports. A return only underflows after the caller's locals have been pushed out of the file, which takes a large caller frame, a call, and an allocate past capacity whose spills are acknowledged. The stimulus builds exactly that chain and then returns. A second chain pushes the base past the end of the file and back again through a return that needs no stall.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CALL  = 2'b01,
        OP_ALLOC = 2'b10,
        OP_RET   = 2'b11
    } frame_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SPILL = 2'b01,
        ST_FILL  = 2'b10
    } ctrl_state_e;
endpackage

// File: rtl/rsf_next_frame.sv
module rsf_next_frame
    import rsf_pkg::*;
#(
    parameter int NPHYS = 96,
    parameter int FW    = 7,
    parameter int SW    = 9
) (
    input  frame_op_e         op,
    input  logic [FW-1:0]     ins,
    input  logic [FW-1:0]     locs,
    input  logic [FW-1:0]     outs,
    input  logic [FW-1:0]     cur_sof,
    input  logic [FW-1:0]     cur_sol,
    input  logic [FW-1:0]     prev_sof,
    input  logic [FW-1:0]     prev_sol,
    input  logic [FW-1:0]     resident,
    input  logic [FW-1:0]     base,
    output logic [FW-1:0]     nxt_sof,
    output logic [FW-1:0]     nxt_sol,
    output logic [FW-1:0]     nxt_prev_sof,
    output logic [FW-1:0]     nxt_prev_sol,
    output logic [FW-1:0]     nxt_base,
    output logic [FW-1:0]     res_add,
    output logic [FW-1:0]     res_sub,
    output logic [FW-1:0]     spill_need,
    output logic [FW-1:0]     fill_need,
    output logic              reject
);
    localparam logic [SW-1:0] LIM = SW'(NPHYS);

    logic [SW-1:0] total_w;
    logic [SW-1:0] inloc_w;
    logic [SW-1:0] base_w;
    logic [SW-1:0] fill_w;
    logic [SW-1:0] after_w;
    logic [SW-1:0] occ_w;
    logic [SW-1:0] spill_w;

    function automatic logic [SW-1:0] wrap_fwd(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic [SW-1:0] s;
        s = a + b;
        if (s >= LIM) s = s - LIM;
        return s;
    endfunction

    function automatic logic [SW-1:0] wrap_back(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic [SW-1:0] s;
        s = a + LIM - b;
        if (s >= LIM) s = s - LIM;
        return s;
    endfunction

    always_comb begin
        total_w      = SW'(ins) + SW'(locs) + SW'(outs);
        inloc_w      = SW'(ins) + SW'(locs);
        nxt_sof      = cur_sof;
        nxt_sol      = cur_sol;
        nxt_prev_sof = prev_sof;
        nxt_prev_sol = prev_sol;
        base_w       = SW'(base);
        res_add      = '0;
        res_sub      = '0;
        reject       = 1'b0;
        case (op)
            OP_CALL: begin
                nxt_sof      = cur_sof - cur_sol;
                nxt_sol      = '0;
                nxt_prev_sof = cur_sof;
                nxt_prev_sol = cur_sol;
                base_w       = wrap_fwd(SW'(base), SW'(cur_sol));
                res_add      = cur_sol;
            end
            OP_ALLOC: begin
                if (total_w > LIM) begin
                    reject = 1'b1;
                end else begin
                    nxt_sof = FW'(total_w);
                    nxt_sol = FW'(inloc_w);
                end
            end
            OP_RET: begin
                nxt_sof = prev_sof;
                nxt_sol = prev_sol;
                base_w  = wrap_back(SW'(base), SW'(prev_sol));
                res_sub = prev_sol;
            end
            default: begin
            end
        endcase
        nxt_base = FW'(base_w);

        // registers of the restored caller that are no longer in the file
        fill_w  = (SW'(res_sub) > SW'(resident)) ? (SW'(res_sub) - SW'(resident)) : '0;
        after_w = SW'(resident) + fill_w + SW'(res_add) - SW'(res_sub);
        occ_w   = after_w + SW'(nxt_sof);
        spill_w = (occ_w > LIM) ? (occ_w - LIM) : '0;

        spill_need = reject ? '0 : FW'(spill_w);
        fill_need  = reject ? '0 : FW'(fill_w);
    end
endmodule

// File: rtl/rsf_xlate.sv
module rsf_xlate #(
    parameter int NSTATIC = 32,
    parameter int NPHYS   = 96,
    parameter int VW      = 7,
    parameter int FW      = 7,
    parameter int SW      = 9
) (
    input  logic [VW-1:0] vreg,
    input  logic [FW-1:0] base,
    input  logic [FW-1:0] sof,
    output logic [VW-1:0] idx,
    output logic          is_static,
    output logic          legal
);
    localparam logic [SW-1:0] LIM = SW'(NPHYS);
    localparam logic [SW-1:0] STB = SW'(NSTATIC);

    logic [SW-1:0] v_w;
    logic [SW-1:0] off_w;
    logic [SW-1:0] pos_w;

    always_comb begin
        v_w   = SW'(vreg);
        off_w = v_w - STB;
        pos_w = SW'(base) + off_w;
        if (pos_w >= LIM) pos_w = pos_w - LIM;
        if (v_w < STB) begin
            idx       = vreg;
            is_static = 1'b1;
            legal     = 1'b1;
        end else begin
            is_static = 1'b0;
            legal     = (off_w < SW'(sof));
            idx       = legal ? VW'(pos_w) : '0;
        end
    end
endmodule

// File: rtl/rsf_resident.sv
module rsf_resident #(
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spill_pulse,
    input  logic          fill_pulse,
    input  logic          commit,
    input  logic [FW-1:0] add_amt,
    input  logic [FW-1:0] sub_amt,
    output logic [FW-1:0] count
);
    logic [FW-1:0] cnt_q;
    logic [FW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q - FW'(spill_pulse) + FW'(fill_pulse);
        if (commit) cnt_d = cnt_d + add_amt - sub_amt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R7: a spill can only move out a register that is resident
    p_spill_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spill_pulse |-> (cnt_q != '0));
endmodule

// File: rtl/reg_stack_renamer.sv
module reg_stack_renamer
    import rsf_pkg::*;
#(
    parameter  int NSTATIC = 32,
    parameter  int NPHYS   = 96,
    localparam int VW      = $clog2(NSTATIC + NPHYS),
    localparam int FW      = $clog2(NPHYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [FW-1:0] alloc_ins,
    input  logic [FW-1:0] alloc_locs,
    input  logic [FW-1:0] alloc_outs,
    output logic          cmd_ready,
    input  logic          spill_ack,
    input  logic          fill_ack,
    output logic          ovf_req,
    output logic [FW-1:0] ovf_count,
    output logic          unf_req,
    output logic [FW-1:0] unf_count,
    input  logic [VW-1:0] vreg_num,
    output logic [VW-1:0] map_idx,
    output logic          map_static,
    output logic          map_legal,
    output logic [FW-1:0] frame_sof,
    output logic [FW-1:0] frame_sol
);
    localparam int            SW  = ((VW > FW) ? VW : FW) + 2;
    localparam logic [SW-1:0] LIM = SW'(NPHYS);
    localparam logic [FW-1:0] ONE = FW'(1);

    ctrl_state_e   state_q;
    ctrl_state_e   state_d;
    frame_op_e     op_w;

    logic [FW-1:0] sof_q, sol_q, psof_q, psol_q, base_q, remain_q;
    logic [FW-1:0] pd_sof, pd_sol, pd_psof, pd_psol, pd_base, pd_add, pd_sub;
    logic [FW-1:0] c_sof, c_sol, c_psof, c_psol, c_base, c_add, c_sub, c_spill, c_fill;
    logic          c_reject;
    logic [FW-1:0] res_cnt;

    logic accept, commit_now, commit_pend, last_spill, last_fill;
    logic spill_pulse, fill_pulse;
    logic [FW-1:0] res_add_w, res_sub_w;

    assign op_w = frame_op_e'(cmd_op);

    rsf_next_frame #(.NPHYS(NPHYS), .FW(FW), .SW(SW)) u_next (
        .op(op_w), .ins(alloc_ins), .locs(alloc_locs), .outs(alloc_outs),
        .cur_sof(sof_q), .cur_sol(sol_q), .prev_sof(psof_q), .prev_sol(psol_q),
        .resident(res_cnt), .base(base_q),
        .nxt_sof(c_sof), .nxt_sol(c_sol), .nxt_prev_sof(c_psof), .nxt_prev_sol(c_psol),
        .nxt_base(c_base), .res_add(c_add), .res_sub(c_sub),
        .spill_need(c_spill), .fill_need(c_fill), .reject(c_reject)
    );

    rsf_xlate #(.NSTATIC(NSTATIC), .NPHYS(NPHYS), .VW(VW), .FW(FW), .SW(SW)) u_xlate (
        .vreg(vreg_num), .base(base_q), .sof(sof_q),
        .idx(map_idx), .is_static(map_static), .legal(map_legal)
    );

    // control decode
    assign accept      = cmd_valid && (state_q == ST_IDLE) && (op_w != OP_NONE) && !c_reject;
    assign commit_now  = accept && (c_spill == '0) && (c_fill == '0);
    assign spill_pulse = (state_q == ST_SPILL) && spill_ack;
    assign fill_pulse  = (state_q == ST_FILL) && fill_ack;
    assign last_spill  = spill_pulse && (remain_q == ONE);
    assign last_fill   = fill_pulse && (remain_q == ONE);
    assign commit_pend = last_spill || last_fill;
    assign res_add_w   = commit_now ? c_add : pd_add;
    assign res_sub_w   = commit_now ? c_sub : pd_sub;

    rsf_resident #(.FW(FW)) u_res (
        .clk(clk), .rst_n(rst_n),
        .spill_pulse(spill_pulse), .fill_pulse(fill_pulse),
        .commit(commit_now || commit_pend),
        .add_amt(res_add_w), .sub_amt(res_sub_w),
        .count(res_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && (c_spill != '0))     state_d = ST_SPILL;
                else if (accept && (c_fill != '0)) state_d = ST_FILL;
                else                               state_d = ST_IDLE;
            end
            ST_SPILL: state_d = last_spill ? ST_IDLE : ST_SPILL;
            ST_FILL:  state_d = last_fill ? ST_IDLE : ST_FILL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        ovf_req   = (state_q == ST_SPILL);
        unf_req   = (state_q == ST_FILL);
        ovf_count = ovf_req ? remain_q : '0;
        unf_count = unf_req ? remain_q : '0;
        frame_sof = sof_q;
        frame_sol = sol_q;
    end

    // frame marker, saved marker, base and pending command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_q    <= '0;
            sol_q    <= '0;
            psof_q   <= '0;
            psol_q   <= '0;
            base_q   <= '0;
            remain_q <= '0;
            pd_sof   <= '0;
            pd_sol   <= '0;
            pd_psof  <= '0;
            pd_psol  <= '0;
            pd_base  <= '0;
            pd_add   <= '0;
            pd_sub   <= '0;
        end else begin
            if (accept) begin
                pd_sof   <= c_sof;
                pd_sol   <= c_sol;
                pd_psof  <= c_psof;
                pd_psol  <= c_psol;
                pd_base  <= c_base;
                pd_add   <= c_add;
                pd_sub   <= c_sub;
                remain_q <= (c_spill != '0) ? c_spill : c_fill;
            end else if (spill_pulse || fill_pulse) begin
                remain_q <= remain_q - ONE;
            end
            if (commit_now) begin
                sof_q  <= c_sof;
                sol_q  <= c_sol;
                psof_q <= c_psof;
                psol_q <= c_psol;
                base_q <= c_base;
            end else if (commit_pend) begin
                sof_q  <= pd_sof;
                sol_q  <= pd_sol;
                psof_q <= pd_psof;
                psol_q <= pd_psol;
                base_q <= pd_base;
            end
        end
    end

    p_sol_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sol_q <= sof_q);

    p_resident_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> ((SW'(res_cnt) + SW'(sof_q)) <= LIM));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && !spill_ack) |=> (ovf_req && $stable(sof_q) && $stable(base_q)));

    p_spill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && spill_ack && (ovf_count != ONE)) |=> (ovf_count == ($past(ovf_count) - ONE)));

    p_fill_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_req && fill_ack && (unf_count != ONE)) |=> (unf_count == ($past(unf_count) - ONE)));

    p_single_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_req && unf_req));

    p_map_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_legal && !map_static) |-> (SW'(map_idx) < LIM));

    p_call_clears_locals_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (op_w == OP_CALL)) |=> (sol_q == '0));
endmodule

// File: tb/reg_stack_renamer_tb.sv
`timescale 1ns/1ps
module reg_stack_renamer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [6:0] alloc_ins = '0, alloc_locs = '0, alloc_outs = '0;
    logic       cmd_ready;
    logic       spill_ack = 1'b0, fill_ack = 1'b0;
    logic       ovf_req, unf_req;
    logic [6:0] ovf_count, unf_count;
    logic [6:0] vreg_num = '0;
    logic [6:0] map_idx;
    logic       map_static, map_legal;
    logic [6:0] frame_sof, frame_sol;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    reg_stack_renamer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .alloc_ins(alloc_ins), .alloc_locs(alloc_locs), .alloc_outs(alloc_outs),
        .cmd_ready(cmd_ready), .spill_ack(spill_ack), .fill_ack(fill_ack),
        .ovf_req(ovf_req), .ovf_count(ovf_count), .unf_req(unf_req), .unf_count(unf_count),
        .vreg_num(vreg_num), .map_idx(map_idx), .map_static(map_static), .map_legal(map_legal),
        .frame_sof(frame_sof), .frame_sol(frame_sol)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [1:0] op, input int i, input int l, input int o);
        cmd_op = op; alloc_ins = 7'(i); alloc_locs = 7'(l); alloc_outs = 7'(o);
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 2'b00;
    endtask

    task automatic do_alloc(input int i, input int l, input int o); issue(2'b10, i, l, o); endtask
    task automatic do_call();   issue(2'b01, 0, 0, 0); endtask
    task automatic do_ret();    issue(2'b11, 0, 0, 0); endtask

    task automatic pulse_spill(input int n);
        for (int k = 0; k < n; k++) begin
            spill_ack = 1'b1;
            @(posedge clk);
            @(negedge clk);
            spill_ack = 1'b0;
        end
    endtask

    task automatic pulse_fill(input int n);
        for (int k = 0; k < n; k++) begin
            fill_ack = 1'b1;
            @(posedge clk);
            @(negedge clk);
            fill_ack = 1'b0;
        end
    endtask

    task automatic check_map(input string tag, input int v, input int exp_idx,
                             input int exp_legal, input int exp_static);
        vreg_num = 7'(v);
        #1;
        check({tag, " legal"}, int'(map_legal), exp_legal);
        check({tag, " static"}, int'(map_static), exp_static);
        if (exp_legal != 0) check({tag, " idx"}, int'(map_idx), exp_idx);
    endtask

    task automatic check_frame(input string tag, input int sof, input int sol);
        check({tag, " sof"}, int'(frame_sof), sof);
        check({tag, " sol"}, int'(frame_sol), sol);
    endtask

    task automatic t_reset();
        do_reset();
        check("R6 ready", int'(cmd_ready), 1);
        check("R6 ovf_req", int'(ovf_req), 0);
        check("R6 unf_req", int'(unf_req), 0);
        check_frame("R6", 0, 0);
        check_map("R1 v5", 5, 5, 1, 1);
        check_map("R1 v31", 31, 31, 1, 1);
        check_map("R2 v40 empty frame", 40, 0, 0, 0);
    endtask

    task automatic t_basic();
        do_alloc(2, 12, 7);
        check_frame("R3 alloc", 21, 14);
        check_map("R2 v32", 32, 0, 1, 0);
        check_map("R2 v52", 52, 20, 1, 0);
        check_map("R2 v53 beyond", 53, 0, 0, 0);
        do_call();
        check_frame("R4 call", 7, 0);
        check("R4 ready", int'(cmd_ready), 1);
        check_map("R4 v32", 32, 14, 1, 0);
        check_map("R4 v38", 38, 20, 1, 0);
        check_map("R4 v39 beyond", 39, 0, 0, 0);
        do_alloc(7, 9, 3);
        check_frame("R3 callee alloc", 19, 16);
        check_map("R3 base kept", 32, 14, 1, 0);
        do_ret();
        check_frame("R5 ret", 21, 14);
        check_map("R5 v33", 33, 1, 1, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        do_alloc(0, 60, 20);
        do_call();
        check_map("R4 base60", 32, 60, 1, 0);
        do_alloc(0, 40, 10);
        check("R7 ovf_req", int'(ovf_req), 1);
        check("R7 ovf_count", int'(ovf_count), 14);
        check("R7 ready low", int'(cmd_ready), 0);
        check_frame("R7 held", 20, 0);
        pulse_spill(13);
        check("R7 count at 1", int'(ovf_count), 1);
        check("R7 still stalled", int'(cmd_ready), 0);
        check("R7 no unf", int'(unf_req), 0);
        check_map("R7 map held", 32, 60, 1, 0);
        pulse_spill(1);
        check("R7 released", int'(cmd_ready), 1);
        check("R7 ovf cleared", int'(ovf_req), 0);
        check_frame("R7 committed", 50, 40);
        check_map("R2 wrap v72", 72, 4, 1, 0);
    endtask

    task automatic t_underflow();
        do_ret();
        check("R8 unf_req", int'(unf_req), 1);
        check("R8 unf_count", int'(unf_count), 14);
        check("R8 ready low", int'(cmd_ready), 0);
        check_frame("R8 held", 50, 40);
        pulse_fill(13);
        check("R8 count at 1", int'(unf_count), 1);
        pulse_fill(1);
        check("R8 released", int'(cmd_ready), 1);
        check("R8 unf cleared", int'(unf_req), 0);
        check_frame("R8 restored", 80, 60);
        check_map("R5 base back", 32, 0, 1, 0);
    endtask

    task automatic t_reject();
        do_alloc(50, 40, 10);
        check_frame("R9 oversize dropped", 80, 60);
        check("R9 ready", int'(cmd_ready), 1);
        do_alloc(0, 90, 6);
        check_frame("R9 exact 96", 96, 90);
        check("R9 no stall", int'(ovf_req), 0);
    endtask

    task automatic t_stray_ack();
        pulse_spill(1);
        pulse_fill(1);
        check("R10 no ovf after stray", int'(ovf_req), 0);
        check("R10 no unf after stray", int'(unf_req), 0);
        do_call();
        check_frame("R10 call", 6, 0);
        do_alloc(0, 0, 10);
        check("R10 shortfall intact", int'(ovf_count), 4);
        pulse_spill(4);
        check_frame("R10 committed", 10, 0);
        check_map("R10 v32", 32, 90, 1, 0);
        check_map("R2 wrap v38", 38, 0, 1, 0);
    endtask

    task automatic t_ret_wrap();
        do_reset();
        do_alloc(0, 50, 10);
        do_call();
        do_alloc(0, 50, 10);
        check("R7 second shortfall", int'(ovf_count), 14);
        pulse_spill(14);
        do_call();
        check_map("R4 base wraps", 32, 4, 1, 0);
        do_ret();
        check("R5 no stall", int'(cmd_ready), 1);
        check_frame("R5 wrap ret", 60, 50);
        check_map("R5 base back wraps", 32, 50, 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_overflow();
        t_underflow();
        t_reject();
        t_stray_ack();
        t_ret_wrap();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule